// File: doc/BRIEF.md
# General Register Datapath with ALU

This block is a single-cycle processor datapath. A bank of seven 8-bit general registers feeds two independent source selectors. One selector drives operand bus A and the other drives operand bus B. An ALU combines the two buses, and its result appears on an output bus. That output bus loops back to every register. A destination decoder then enables the load of at most one register at the rising clock edge.

The block is controlled by one 13-bit control word, applied every cycle. The word has four fields: the bus A source, the bus B source, the ALU operation and the destination. For example, `R1 <- R2 + R3` takes one cycle. The bus A field names R2, the bus B field names R3, the operation is add, and the destination names R1.

An external data input can be chosen onto either operand bus. The output bus and two flags, carry and zero, are visible at the ports. Writing back can be suppressed, so the result is only observed. This is also how a register is read out: transfer it with no destination.

Top module: `grdp_datapath`

## Requirements
- R1: A synchronous active-high reset clears all seven registers to zero. After reset, every register reads back as 0.
- R2: The bus A field is `ctrl_word[12:10]`. Code k in 1..7 places register Rk on bus A. Code 0 places `ext_data` on bus A.
- R3: The bus B field is `ctrl_word[9:7]`. Code k in 1..7 places register Rk on bus B. Code 0 places `ext_data` on bus B.
- R4: The operation field is `ctrl_word[6:3]`. Its codes are:
  - 0: A
  - 1: A+1
  - 2: A+B
  - 3: A-B
  - 4: A-1
  - 5: A AND B
  - 6: A OR B
  - 7: A XOR B
  - 8: NOT A
  - 9: A shifted left by one, with 0 filled in
  - 10: A shifted right by one, logically, with 0 filled in

  All arithmetic is modulo 256. The result appears combinationally on `out_bus`.
- R5: `carry_o` is combinational. For code 2 it is the carry out of A+B. For code 3 it is 1 exactly when A < B (unsigned borrow). For every other code it is 0.
- R6: `zero_o` is combinational. It is 1 exactly when `out_bus` is 0.
- R7: The destination field is `ctrl_word[2:0]`. Code k in 1..7 writes `out_bus` into Rk at the rising edge. All other registers keep their values.
- R8: Destination code 0 writes no register. The result is visible only on `out_bus` for that cycle.
- R9: When a source register is also the destination, the operands use the value held before the edge. The new value is readable from the next cycle.
- R10: Operation codes 11 to 15 pass A to `out_bus` unchanged, with `carry_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 13 | Control word, fields `{srcA[12:10], srcB[9:7], op[6:3], dest[2:0]}` |
| ext_data | input | 8 | External operand, selectable onto either bus with code 0 |
| out_bus | output | 8 | ALU result bus, also the write-back data |
| carry_o | output | 1 | Carry/borrow of add and subtract |
| zero_o | output | 1 | High when `out_bus` is zero |

## Verification
The result bus and both flags depend on the control word and on the register contents latched at the previous edge. They are therefore due in the same cycle as the control word. A register write appears only in the results of the following cycle. The bench drives each control word on the falling edge and samples the outputs 1 ns later, well before the next rising edge. Only after that comparison does it commit the write into its reference model. A write is therefore always judged one cycle after it is issued, through a later read on either bus.

// File: rtl/grdp_pkg.sv
`timescale 1ns/1ps
package grdp_pkg;
    parameter int WIDTH  = 8;
    parameter int NREG   = 7;
    parameter int SEL_W  = 3;
    parameter int OPR_W  = 4;
    localparam int CTRL_W = 3 * SEL_W + OPR_W;

    typedef logic [WIDTH-1:0] word_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [OPR_W-1:0] {
        OP_PASS = 4'd0,
        OP_INC  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_DEC  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_NOT  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10
    } alu_op_e;

    typedef struct packed {
        sel_t              src_a;
        sel_t              src_b;
        logic [OPR_W-1:0]  op;
        sel_t              dest;
    } ctrl_t;

    typedef struct packed {
        word_t value;
        logic  carry;
        logic  zero;
    } alu_res_t;

    function automatic logic is_carry_op(logic [OPR_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction
endpackage

// File: rtl/grdp_alu.sv
`timescale 1ns/1ps
module grdp_alu
    import grdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  word_t             a,
    input  word_t             b,
    input  logic [OPR_W-1:0]  op,
    output alu_res_t          res
);
    logic [WIDTH:0] wide;

    always_comb begin
        wide = '0;
        case (op)
            OP_PASS: wide = {1'b0, a};
            OP_INC:  wide = {1'b0, a + word_t'(1)};
            OP_ADD:  wide = {1'b0, a} + {1'b0, b};
            OP_SUB:  wide = {1'b0, a} - {1'b0, b};
            OP_DEC:  wide = {1'b0, a - word_t'(1)};
            OP_AND:  wide = {1'b0, a & b};
            OP_OR:   wide = {1'b0, a | b};
            OP_XOR:  wide = {1'b0, a ^ b};
            OP_NOT:  wide = {1'b0, ~a};
            OP_SHL:  wide = {1'b0, a[WIDTH-2:0], 1'b0};
            OP_SHR:  wide = {2'b00, a[WIDTH-1:1]};
            default: wide = {1'b0, a};
        endcase
        res.value = wide[WIDTH-1:0];
        res.carry = wide[WIDTH];
        res.zero  = (wide[WIDTH-1:0] == '0);
    end

    // R5
    carry_only_arith_chk: assert property (@(posedge clk) disable iff (rst)
        !is_carry_op(op) |-> !res.carry);

    // R10
    unused_op_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (op > OPR_W'(OP_SHR)) |-> (res.value == a));
endmodule

// File: rtl/grdp_regbank.sv
`timescale 1ns/1ps
module grdp_regbank
    import grdp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sel_t  src_a,
    input  sel_t  src_b,
    input  sel_t  dest,
    input  word_t ext_data,
    input  word_t wr_data,
    output word_t bus_a,
    output word_t bus_b
);
    word_t            regs [NREG];
    logic [NREG-1:0]  load;

    always_comb begin
        load = '0;
        for (int i = 0; i < NREG; i++)
            load[i] = (dest == sel_t'(i + 1));
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)          regs[g] <= '0;
                else if (load[g]) regs[g] <= wr_data;
            end

            // R7
            hold_unselected_chk: assert property (@(posedge clk) disable iff (rst)
                (dest != sel_t'(g + 1)) |=> $stable(regs[g]));

            // R7
            write_selected_chk: assert property (@(posedge clk) disable iff (rst)
                (dest == sel_t'(g + 1)) |=> (regs[g] == $past(wr_data)));
        end
    endgenerate

    always_comb begin
        bus_a = ext_data;
        bus_b = ext_data;
        for (int i = 0; i < NREG; i++) begin
            if (src_a == sel_t'(i + 1)) bus_a = regs[i];
            if (src_b == sel_t'(i + 1)) bus_b = regs[i];
        end
    end

    // R8
    one_load_max_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load));

    // R2
    ext_on_a_chk: assert property (@(posedge clk) disable iff (rst)
        (src_a == '0) |-> (bus_a == ext_data));
endmodule

// File: rtl/grdp_datapath.sv
`timescale 1ns/1ps
module grdp_datapath
    import grdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       ctrl_word,
    input  logic [7:0]        ext_data,
    output logic [7:0]        out_bus,
    output logic              carry_o,
    output logic              zero_o
);
    ctrl_t    cw;
    word_t    bus_a;
    word_t    bus_b;
    alu_res_t res;

    assign cw = ctrl_t'(ctrl_word);

    grdp_regbank u_bank (
        .clk      (clk),
        .rst      (rst),
        .src_a    (cw.src_a),
        .src_b    (cw.src_b),
        .dest     (cw.dest),
        .ext_data (ext_data),
        .wr_data  (res.value),
        .bus_a    (bus_a),
        .bus_b    (bus_b)
    );

    grdp_alu u_alu (
        .clk (clk),
        .rst (rst),
        .a   (bus_a),
        .b   (bus_b),
        .op  (cw.op),
        .res (res)
    );

    assign out_bus = res.value;
    assign carry_o = res.carry;
    assign zero_o  = res.zero;

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        zero_o |-> (out_bus == '0));
endmodule

// File: tb/tb_grdp_datapath.sv
`timescale 1ns/1ps
module tb_grdp_datapath;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] ctrl_word = '0;
    logic [7:0]  ext_data = '0;
    logic [7:0]  out_bus;
    logic        carry_o;
    logic        zero_o;

    int checks = 0;
    int fails  = 0;
    int model [1:7];
    bit finished = 0;

    always #2.5 clk = ~clk;

    grdp_datapath dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .ext_data(ext_data), .out_bus(out_bus),
        .carry_o(carry_o), .zero_o(zero_o)
    );

    function automatic int operand(int sel, int ext);
        return (sel == 0) ? ext : model[sel];
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(int sa, int sb, int op, int sd, int ext, string tag);
        int a, b, r, c;
        @(negedge clk);
        ctrl_word = {3'(sa), 3'(sb), 4'(op), 3'(sd)};
        ext_data  = 8'(ext);
        a = operand(sa, ext);
        b = operand(sb, ext);
        c = 0;
        case (op)
            0: r = a;
            1: r = a + 1;
            2: begin r = a + b; c = (r > 255); end
            3: begin r = a - b; c = (a < b); end
            4: r = a - 1;
            5: r = a & b;
            6: r = a | b;
            7: r = a ^ b;
            8: r = ~a;
            9: r = a << 1;
            10: r = a >> 1;
            default: r = a;
        endcase
        r = r & 255;
        #1;
        check(tag, int'(out_bus), r);
        check((op == 2 || op == 3) ? "R5" : {tag, "/R5"}, int'(carry_o), c);
        check("R6", int'(zero_o), (r == 0) ? 1 : 0);
        if (sd != 0) model[sd] = r;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 1; i <= 7; i++) model[i] = 0;
    endtask

    initial begin
        for (int i = 1; i <= 7; i++) model[i] = 0;
        do_reset();
        for (int i = 1; i <= 7; i++) step(i, i, 0, 0, 8'hA5, "R1");

        // R2/R3: load through external data onto either bus
        for (int i = 1; i <= 7; i++) step(0, i, 0, i, 16 * i + 3, "R2");
        for (int i = 1; i <= 7; i++) step(i, 0, 5, 0, 8'hF0, "R3");
        // R7: the R1 <- R2 + R3 example and hold of the others
        step(2, 3, 2, 1, 0, "R7");
        for (int i = 1; i <= 7; i++) step(i, 0, 0, 0, 0, "R7");
        // R8: destination 0 writes nothing
        step(0, 0, 2, 0, 8'h77, "R8");
        for (int i = 1; i <= 7; i++) step(i, 0, 0, 0, 0, "R8");
        // R9: same register as source and destination
        step(4, 4, 2, 4, 0, "R9");
        step(4, 4, 1, 4, 0, "R9");
        step(4, 0, 0, 0, 0, "R9");
        // R5/R6 corners
        step(0, 0, 3, 5, 8'h00, "R6");
        step(5, 0, 4, 6, 8'h00, "R4");
        step(6, 0, 2, 0, 8'h01, "R5");
        step(6, 0, 3, 0, 8'h01, "R5");
        step(0, 0, 2, 0, 8'h80, "R5");
        // R4: every operation code with the external operand
        for (int op = 0; op <= 10; op++) step(0, 2, op, 0, 8'h96, "R4");
        // R10: unused codes
        for (int op = 11; op <= 15; op++) step(3, 2, op, 0, 8'h00, "R10");
        // random micro-operations
        for (int n = 0; n < 600; n++)
            step($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 15),
                 $urandom_range(0, 7), $urandom_range(0, 255), "R4");
        // R1: reset after registers hold data
        do_reset();
        for (int i = 1; i <= 7; i++) step(i, i, 6, 0, 0, "R1");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule